// File: doc/BRIEF.md
# Burst Address Offset Sequencer

This block produces the address for each beat of a short burst of up to four beats. A load captures a full starting address. After that, each advance moves to the next beat without the address being presented again. The two low address bits then follow one of two orders, and each order wraps inside the aligned group of four that holds the starting address. The upper address bits are kept as they were loaded.

A static order-select input chooses the order. When it is high, the offset is the starting offset XOR the beat count. This interleaved order suits caches that fetch the critical word first. When it is low, the offset is the starting offset plus the beat count, modulo four, which gives a linear wrapping order. A clock enable gates every state change, so a stalled pipeline holds the burst where it is. The current beat index is also an output, so the datapath can tag each beat.

Top module: `burst_offset_seq`

## Requirements
- R1: After reset, `addr_out` is all zeros and `beat_idx` is 0.
- R2: At a clock edge with `clk_en` high and `load` high, the block captures `start_addr` and clears `beat_idx` to 0. From the next cycle, `addr_out` equals the captured `start_addr`.
- R3: At a clock edge with `clk_en` high, `advance` high and `load` low, `beat_idx` increments by one modulo 4, so beat 3 is followed by beat 0.
- R4: With `order_sel` high (interleaved order), `addr_out[1:0]` equals the captured start bits [1:0] XOR `beat_idx`. Starting from 01, for example, the offsets run 01, 00, 11, 10.
- R5: With `order_sel` low (linear order), `addr_out[1:0]` equals the captured start bits [1:0] plus `beat_idx`, modulo 4. Starting from 11, for example, the offsets run 11, 00, 01, 10.
- R6: `addr_out[ADDR_W-1:2]` always equals bits [ADDR_W-1:2] of the last captured `start_addr`, and an advance never changes them.
- R7: At an edge with `clk_en` low, neither `load` nor `advance` has any effect, so `beat_idx` and `addr_out` keep their values.
- R8: When `load` and `advance` are both high at an enabled edge, the load wins and `beat_idx` becomes 0.
- R9: At an enabled edge with neither `load` nor `advance` high, the state is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable that gates every state change |
| load | input | 1 | Capture `start_addr` and begin a new burst |
| advance | input | 1 | Step to the next beat |
| order_sel | input | 1 | 1 = interleaved (XOR) order, 0 = linear wrapping order |
| start_addr | input | ADDR_W | Starting address of the burst |
| addr_out | output | ADDR_W | Address of the current beat |
| beat_idx | output | 2 | Index of the current beat, 0 to 3 |

## Verification
Each load or advance takes effect at the clock edge where it is sampled. The new `beat_idx` and `addr_out` are therefore due in the following cycle, and never later. The bench drives its inputs on the falling edge and lets one rising edge pass. It compares the outputs on the next falling edge, before it applies the next stimulus, against a model that was advanced once per enabled edge. Because `order_sel` feeds the offset without a register, a change in mode shows up in that same compare. The bench changes the mode only together with a load.

// File: rtl/burst_offset_seq.sv
module burst_offset_seq #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              load,
  input  logic              advance,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        beat_idx
);

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] base_hi;
  logic [1:0]      base_lo;
  logic [1:0]      beat_q;
  logic [1:0]      offset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi <= '0;
      base_lo <= '0;
      beat_q  <= '0;
    end else if (clk_en) begin
      if (load) begin
        base_hi <= start_addr[ADDR_W-1:2];
        base_lo <= start_addr[1:0];
        beat_q  <= '0;
      end else if (advance) begin
        beat_q  <= beat_q + 2'd1;
      end
    end
  end

  assign offset   = order_sel ? (base_lo ^ beat_q) : (base_lo + beat_q);
  assign addr_out = {base_hi, offset};
  assign beat_idx = beat_q;

endmodule

// File: rtl/burst_offset_seq_chk.sv
module burst_offset_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              load,
  input logic              advance,
  input logic              order_sel,
  input logic [ADDR_W-1:0] start_addr,
  input logic [ADDR_W-1:0] addr_out,
  input logic [1:0]        beat_idx
);

  p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && load |=> beat_idx == 2'd0 && addr_out == $past(start_addr));

  p_beat_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && advance && !load |=> beat_idx == $past(beat_idx) + 2'd1);

  p_xor_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && advance && !load && order_sel |=>
      (!order_sel || addr_out[1:0] == ($past(addr_out[1:0]) ^ $past(beat_idx) ^ beat_idx)));

  p_lin_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && advance && !load && !order_sel |=>
      (order_sel || addr_out[1:0] == $past(addr_out[1:0]) + 2'd1));

  p_upper_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_en && load) |=> $stable(addr_out[ADDR_W-1:2]));

  p_no_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(beat_idx));

  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && load && advance |=> beat_idx == 2'd0);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && !load && !advance |=> $stable(beat_idx));

endmodule

bind burst_offset_seq burst_offset_seq_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/burst_offset_seq_tb_top.sv
module burst_offset_seq_tb_top;
  localparam int ADDR_W = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              clk_en = 1'b0, load = 1'b0, advance = 1'b0, order_sel = 1'b1;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [ADDR_W-1:0] addr_out;
  logic [1:0]        beat_idx;

  int vectors = 0, errors = 0;
  logic [ADDR_W-1:0] m_base = '0;
  logic [1:0]        m_beat = '0;
  logic [ADDR_W-1:0] m_addr;
  logic [1:0]        m_lo;
  logic [1:0]        m_cur_beat;

  burst_offset_seq #(.ADDR_W(ADDR_W)) dut_i (.*);

  always #4 clk = ~clk;

  function automatic logic [ADDR_W-1:0] exp_addr(input logic [ADDR_W-1:0] b,
                                                 input logic [1:0] bt, input logic ilv);
    logic [1:0] lo;
    lo = ilv ? (b[1:0] ^ bt) : (b[1:0] + bt);
    return {b[ADDR_W-1:2], lo};
  endfunction

  task automatic check(input string tag);
    logic [ADDR_W-1:0] ea;
    ea = exp_addr(m_base, m_beat, order_sel);
    vectors++;
    if (addr_out !== ea || beat_idx !== m_beat) begin
      errors++;
      $display("FAIL %s: addr_out=%h beat_idx=%0d expected addr_out=%h beat_idx=%0d",
               tag, addr_out, beat_idx, ea, m_beat);
    end
  endtask

  task automatic step(input logic en, input logic ld, input logic adv, input logic md,
                      input logic [ADDR_W-1:0] a, input string tag);
    clk_en = en; load = ld; advance = adv; order_sel = md; start_addr = a;
    if (en && ld) begin m_base = a; m_beat = 2'd0; end
    else if (en && adv) m_beat = m_beat + 2'd1;
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // R4 interleaved from 01: 01,00,11,10 then wrap
    step(1, 1, 0, 1, 20'hABCD1, "R2 load");
    step(1, 0, 1, 1, 20'hFFFFF, "R4 beat1");
    step(1, 0, 1, 1, 20'h00000, "R4 beat2");
    step(1, 0, 1, 1, 20'h12345, "R4 beat3");
    step(1, 0, 1, 1, 20'h12345, "R3 wrap");
    // R5 linear from 11: 11,00,01,10
    step(1, 1, 0, 0, 20'h5A5A7, "R2 load lin");
    step(1, 0, 1, 0, 20'h0, "R5 beat1");
    step(1, 0, 1, 0, 20'h0, "R5 beat2");
    step(1, 0, 1, 0, 20'h0, "R5 beat3 R6");
    // R7 enable low
    step(0, 1, 0, 0, 20'h11110, "R7 load ignored");
    step(0, 0, 1, 0, 20'h0, "R7 advance ignored");
    // R8 load beats advance
    step(1, 1, 1, 0, 20'h33332, "R8 load priority");
    // R9 idle hold
    step(1, 0, 0, 0, 20'hFFFFF, "R9 idle");

    void'($urandom(32'd1357));
    for (int i = 0; i < 2000; i++) begin
      logic en, ld, adv, md;
      en  = ($urandom % 8) != 0;
      ld  = ($urandom % 5) == 0;
      adv = ($urandom % 3) != 0;
      md  = (ld && en) ? logic'($urandom % 2) : order_sel;
      step(en, ld, adv, md, ADDR_W'($urandom), "R3 R4 R5 R6 R7 R8 R9 random");
    end
    finish_run();
  end
endmodule